// File: doc/BRIEF.md
# Strobed Parallel Register Port Slave

This block sits on the device side of an 8-bit host bus and exposes a small bank of 8-bit control registers. The host drives three active-low strobes: an address enable, a write strobe and a read strobe. A write strobe with address enable low loads a register pointer from the bus. Write or read strobes with address enable high then access the register that the pointer names. The pointer never steps by itself, so every later access reaches the same register until a new address cycle.

All pins are brought into the system clock through a two-flop synchronizer. Each action fires on the detected rising edge of its strobe. When the qualified reset is released, the levels of the read and write pins decide which side owns the registers. In parallel mode the strobes work as described above. In serial mode the strobes are ignored, the bus pins serve as general-purpose inputs, and a simple synchronous access port used by a separate two-wire decoder reads and writes the registers. A reset pulse is recognised only when it lasts for a minimum number of clock cycles.

Top module: `strobe_port_slave`

## Requirements
- R1: A rising write strobe taken while address enable is low loads the bus value into the register pointer and writes no register.
- R2: A rising write strobe taken while address enable is high stores the bus value into the register the pointer selects.
- R3: While the read strobe is low and address enable is high in parallel mode, `data_oe_o` is high and `data_o` holds the selected register. The output enable follows the strobe three clock edges after the pin changes. A register written in the same cycle that the read begins is returned with its new value.
- R4: The pointer has no auto-increment or auto-decrement. Repeated writes and reads all reach the same register.
- R5: The mode is captured while the qualified reset is active. Read and write pins both low select serial mode (`mode_serial_o`=1). Both high, or mixed levels, select parallel mode (`mode_serial_o`=0).
- R6: Reset takes effect only after `rst` has been high for `MIN_RST_CYC` consecutive cycles (default 13, which is 104 ns at 125 MHz). A shorter pulse leaves the mode, the pointer and the registers unchanged.
- R7: The bank holds `NUM_REGS` registers (default 16). A write to a pointer at or above `NUM_REGS` is ignored, a read of such a pointer returns 0, and no register is aliased.
- R8: In serial mode the parallel strobes are ignored and the output enable stays low. `gpio_o` shows the synchronized bus pins. In parallel mode `gpio_o` is 0.
- R9: The serial access port (`ser_we_i`, `ser_addr_i`, `ser_wdata_i`) writes registers only in serial mode. In that mode `data_o` returns the register at `ser_addr_i` one edge later.
- R10: After reset the output enable is low, the pointer is 0 and `gpio_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, length-qualified |
| adr_en_n | input | 1 | Address enable, active low |
| wr_n | input | 1 | Write strobe, active low; also a mode strap at reset |
| rd_n | input | 1 | Read strobe, active low; also a mode strap at reset |
| data_i | input | DATA_W | Bus value from the pins |
| data_o | output | DATA_W | Read data for the owning port |
| data_oe_o | output | 1 | Bus drive enable |
| mode_serial_o | output | 1 | 1 when the serial side owns the registers |
| gpio_o | output | DATA_W | Bus pins as general-purpose inputs in serial mode |
| ser_we_i | input | 1 | Serial-side write enable |
| ser_addr_i | input | DATA_W | Serial-side register address |
| ser_wdata_i | input | DATA_W | Serial-side write data |

## Verification
A data write and the start of a read can fall in the same clock cycle. This happens when the host releases the write strobe and lowers the read strobe at the same instant, so the register file is written on the same edge that the output enable rises. The bench does exactly that with address enable high and the write data held. Its scoreboard then expects the first driven read cycle to carry the new value and not the stale one.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

  typedef enum logic {
    MODE_PARALLEL = 1'b0,
    MODE_SERIAL   = 1'b1
  } port_mode_e;

  // Only both strap pins low choose the serial owner; anything else is parallel.
  function automatic port_mode_e decode_strap(input logic rd_lvl, input logic wr_lvl);
    return (!rd_lvl && !wr_lvl) ? MODE_SERIAL : MODE_PARALLEL;
  endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    stg_q[0] <= async_i;
    for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sp_reset_qual.sv
module sp_reset_qual
  import strobe_port_pkg::*;
#(
  parameter int MIN_CYC = 13,
  localparam int CNT_W  = $clog2(MIN_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_rd_i,
  input  logic       strap_wr_i,
  output logic       core_rst_o,
  output port_mode_e mode_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q  = '0;
  port_mode_e       mode_q = MODE_PARALLEL;

  assign core_rst_o = rst && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst)              cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (core_rst_o) mode_q <= decode_strap(strap_rd_i, strap_wr_i);
  end

  assign mode_o = mode_q;

  AST_MODE_HELD_OUTSIDE_RESET: assert property (@(posedge clk) disable iff (rst)
    !core_rst_o |=> $stable(mode_q)); // R6

endmodule

// File: rtl/sp_regfile.sv
module sp_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] rdata_q;
  logic              w_in, r_in, same;

  assign w_in = {1'b0, waddr_i} < LIMIT;
  assign r_in = {1'b0, raddr_i} < LIMIT;
  assign same = we_i && w_in && (waddr_i == raddr_i);

  always_ff @(posedge clk) begin
    if (we_i && w_in) mem[waddr_i[IDX_W-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (!r_in) rdata_q <= '0;
    else if (same)  rdata_q <= wdata_i;
    else            rdata_q <= mem[raddr_i[IDX_W-1:0]];
  end

  assign rdata_o = rdata_q;

  AST_OUT_OF_RANGE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, raddr_i} >= LIMIT) |=> (rdata_o == '0)); // R7

  AST_WRITE_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (we_i && ({1'b0, waddr_i} < LIMIT) && (waddr_i == raddr_i)) |=> (rdata_o == $past(wdata_i))); // R3

endmodule

// File: rtl/strobe_port_slave.sv
module strobe_port_slave
  import strobe_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RST_CYC = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adr_en_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              mode_serial_o,
  output logic [DATA_W-1:0] gpio_o,
  input  logic              ser_we_i,
  input  logic [DATA_W-1:0] ser_addr_i,
  input  logic [DATA_W-1:0] ser_wdata_i
);

  localparam int PIN_W = DATA_W + 3;
  localparam int B_ADR = DATA_W;
  localparam int B_WR  = DATA_W + 1;
  localparam int B_RD  = DATA_W + 2;

  logic [PIN_W-1:0]  pin_lvl, pin_rise;
  logic [DATA_W-1:0] bus_s;
  logic              adr_hi, wr_rise, rd_lo;
  logic              core_rst, par;
  port_mode_e        mode;
  logic              addr_hit, data_hit;
  logic [DATA_W-1:0] ptr_q, gpio_q;
  logic              oe_q;
  logic              rf_we;
  logic [DATA_W-1:0] rf_waddr, rf_wdata, rf_raddr;

  sp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .async_i({rd_n, wr_n, adr_en_n, data_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  assign bus_s   = pin_lvl[DATA_W-1:0];
  assign adr_hi  = pin_lvl[B_ADR];
  assign wr_rise = pin_rise[B_WR];
  assign rd_lo   = !pin_lvl[B_RD];

  sp_reset_qual #(.MIN_CYC(MIN_RST_CYC)) u_rstq (
    .clk       (clk),
    .rst       (rst),
    .strap_rd_i(pin_lvl[B_RD]),
    .strap_wr_i(pin_lvl[B_WR]),
    .core_rst_o(core_rst),
    .mode_o    (mode)
  );

  assign par      = (mode == MODE_PARALLEL);
  assign addr_hit = par && wr_rise && !adr_hi;
  assign data_hit = par && wr_rise && adr_hi;

  always_ff @(posedge clk) begin
    if (core_rst)      ptr_q <= '0;
    else if (addr_hit) ptr_q <= bus_s;
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      oe_q   <= 1'b0;
      gpio_q <= '0;
    end else begin
      oe_q   <= par && rd_lo && adr_hi;
      gpio_q <= par ? '0 : bus_s;
    end
  end

  assign rf_we    = par ? data_hit : ser_we_i;
  assign rf_waddr = par ? ptr_q : ser_addr_i;
  assign rf_wdata = par ? bus_s : ser_wdata_i;
  assign rf_raddr = par ? ptr_q : ser_addr_i;

  sp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst    (core_rst),
    .we_i   (rf_we),
    .waddr_i(rf_waddr),
    .wdata_i(rf_wdata),
    .raddr_i(rf_raddr),
    .rdata_o(data_o)
  );

  assign data_oe_o     = oe_q;
  assign mode_serial_o = (mode == MODE_SERIAL);
  assign gpio_o        = gpio_q;

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (core_rst)
    !(wr_rise && !adr_hi) |=> $stable(ptr_q)); // R4

  AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (core_rst)
    mode_serial_o |-> !data_oe_o); // R8

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (core_rst)
    data_oe_o |-> $past(rd_lo && adr_hi)); // R3

  AST_GPIO_QUIET_PARALLEL: assert property (@(posedge clk) disable iff (core_rst)
    (!mode_serial_o && $past(!mode_serial_o)) |-> (gpio_o == '0)); // R8

endmodule

// File: tb/strobe_port_slave_tb_top.sv
module strobe_port_slave_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adr_en_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o, gpio_o;
  logic       data_oe_o, mode_serial_o;
  logic       ser_we_i = 1'b0;
  logic [7:0] ser_addr_i = 8'h00, ser_wdata_i = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       oe_prev = 1'b0;

  always #4 clk = ~clk;

  strobe_port_slave dut_i (
    .clk(clk), .rst(rst), .adr_en_n(adr_en_n), .wr_n(wr_n), .rd_n(rd_n),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .mode_serial_o(mode_serial_o), .gpio_o(gpio_o),
    .ser_we_i(ser_we_i), .ser_addr_i(ser_addr_i), .ser_wdata_i(ser_wdata_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: first driven cycle of each read is compared with the queued value.
  always @(negedge clk) begin
    if (data_oe_o === 1'b1 && oe_prev !== 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected drive actual %h expected none", data_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        if (data_o !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, data_o, e);
        end
      end
    end
    oe_prev = data_oe_o;
  end

  task automatic full_reset(input logic rd_lvl, input logic wr_lvl);
    @(negedge clk);
    adr_en_n = 1'b0; rd_n = rd_lvl; wr_n = wr_lvl; rst = 1'b1;
    idle(20);
    rst = 1'b0;
    idle(1);
    rd_n = 1'b1;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    adr_en_n = 1'b1;
    idle(4);
  endtask

  task automatic addr_cycle(input logic [7:0] a);
    @(negedge clk);
    adr_en_n = 1'b0; data_i = a; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    adr_en_n = 1'b1;
    idle(3);
  endtask

  task automatic write_data(input logic [7:0] d);
    @(negedge clk);
    adr_en_n = 1'b1; data_i = d; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
  endtask

  task automatic read_expect(input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_n = 1'b0;
    idle(5);
    chk({tag, " oe held"}, {7'd0, data_oe_o}, 8'h01);
    chk({tag, " data held"}, data_o, e);
    rd_n = 1'b1;
    idle(5);
    chk({tag, " oe released"}, {7'd0, data_oe_o}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(20);
    rst = 1'b0;
    idle(4);
    chk("R10 oe after reset", {7'd0, data_oe_o}, 8'h00);
    chk("R10 gpio after reset", gpio_o, 8'h00);
    chk("R5 both high parallel", {7'd0, mode_serial_o}, 8'h00);

    // R10: pointer starts at 0, so a write with no address cycle lands in register 0.
    write_data(8'h11);
    read_expect(8'h11, "R10 pointer zero");

    // R1 R2 R3
    addr_cycle(8'h03);
    write_data(8'hA5);
    read_expect(8'hA5, "R2 write then read");
    // R4: no stepping between accesses
    write_data(8'h3C);
    read_expect(8'h3C, "R4 same register again");
    read_expect(8'h3C, "R4 repeated read");

    addr_cycle(8'h07);
    write_data(8'h42);
    addr_cycle(8'h03);
    read_expect(8'h3C, "R1 address cycle wrote nothing");
    addr_cycle(8'h07);
    read_expect(8'h42, "R1 pointer reselect");

    // R9: serial port ignored in parallel mode
    @(negedge clk);
    ser_we_i = 1'b1; ser_addr_i = 8'h07; ser_wdata_i = 8'hEE;
    @(negedge clk);
    ser_we_i = 1'b0;
    read_expect(8'h42, "R9 serial write ignored");

    // R3: write release and read start in the same cycle
    addr_cycle(8'h02);
    @(negedge clk);
    adr_en_n = 1'b1; data_i = 8'h5A; wr_n = 1'b0;
    idle(4);
    exp_q.push_back(8'h5A); tag_q.push_back("R3 same-cycle write and read");
    wr_n = 1'b1; rd_n = 1'b0;
    idle(5);
    chk("R3 collision data held", data_o, 8'h5A);
    rd_n = 1'b1;
    idle(5);

    // R7: out-of-range pointer
    addr_cycle(8'h20);
    write_data(8'h77);
    read_expect(8'h00, "R7 out of range reads zero");
    addr_cycle(8'h00);
    read_expect(8'h11, "R7 no alias into register 0");
    chk("R8 gpio zero in parallel", gpio_o, 8'h00);

    // R6: short pulse is ignored, pointer kept
    addr_cycle(8'h03);
    @(negedge clk);
    rst = 1'b1;
    idle(5);
    rst = 1'b0;
    idle(3);
    chk("R6 short pulse keeps mode", {7'd0, mode_serial_o}, 8'h00);
    read_expect(8'h3C, "R6 short pulse keeps pointer");

    // R5: mixed strap is parallel; R10 pointer back to 0
    full_reset(1'b0, 1'b1);
    chk("R5 mixed strap parallel", {7'd0, mode_serial_o}, 8'h00);
    read_expect(8'h11, "R10 pointer cleared by reset");

    // R5: both low selects serial
    full_reset(1'b0, 1'b0);
    chk("R5 both low serial", {7'd0, mode_serial_o}, 8'h01);
    @(negedge clk);
    ser_we_i = 1'b1; ser_addr_i = 8'h05; ser_wdata_i = 8'h99;
    @(negedge clk);
    ser_we_i = 1'b0;
    idle(2);
    chk("R9 serial write and read", data_o, 8'h99);

    // R8: parallel strobes ignored in serial mode
    addr_cycle(8'h05);
    write_data(8'h00);
    @(negedge clk);
    rd_n = 1'b0;
    idle(5);
    chk("R8 no drive in serial", {7'd0, data_oe_o}, 8'h00);
    rd_n = 1'b1;
    idle(3);
    chk("R8 parallel write ignored", data_o, 8'h99);
    data_i = 8'hC3;
    idle(4);
    chk("R8 gpio mirrors pins", gpio_o, 8'hC3);

    // R6: short pulse with parallel strap keeps serial mode
    @(negedge clk);
    rst = 1'b1;
    idle(5);
    rst = 1'b0;
    idle(3);
    chk("R6 short pulse keeps serial", {7'd0, mode_serial_o}, 8'h01);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 reads never driven actual %0d expected 0", exp_q.size());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule